// File: doc/BRIEF.md
# Two-Word Burst DDR SRAM Command Controller

The controller accepts read and write requests on a valid/ready user port and turns them into commands for an external double-data-rate SRAM. Every address names a pair of data words that move as one burst: a write carries two words and two byte-enable masks, and a read returns two words. The memory shares a single address port between reads and writes and latches a command only on every second rising edge of its clock. Write words go out one per clock edge. Read words come back one per half-cycle, framed by a data-valid strobe from the memory.

The block runs on an internal clock at twice the memory clock rate, so each internal cycle stands for one memory half-cycle. A four-cycle slot counter sets the command cadence and produces the memory clock phase. A static latency-mode input selects between a long read latency (2.5 memory cycles) and a short one (1 memory cycle), and is passed to the memory. The controller never counts read latency. It captures read words only in cycles where the strobe is high and returns each completed pair with the tag it gave the read when the read was issued. When the burst direction changes it inserts an idle slot wherever write data and returning read data could meet on the shared data pins.

Top module: `ddrb_ctrl`

## Requirements
- R1: A command (`mem_rd_en` or `mem_wr_en` high) lasts one cycle and occurs only in a cycle where `mem_k` is high. Two commands are at least 4 cycles apart, which is every second rising edge of the memory clock.
- R2: `mem_rd_en` and `mem_wr_en` are never high in the same cycle.
- R3: For a write command in cycle c, word 0 is on `mem_d` in cycle c+2 and word 1 in cycle c+3. `mem_d_oe` is high in exactly those two cycles.
- R4: `mem_bw` carries `req_be0` with word 0 and `req_be1` with word 1. Bit i enables data bits 9i+8 down to 9i, and a cleared bit leaves that byte of the memory unchanged.
- R5: A request accepted in cycle a (`req_valid` and `req_ready` both high) shows up in cycle a+1 as `mem_wr_en` (write) or `mem_rd_en` (read), with `req_addr` on `mem_addr`. `mem_lat_long` follows `lat_long`.
- R6: Read words are taken only in cycles where `mem_qvld` is high. The first strobed word of a pair is word 0. `rd_valid` pulses for one cycle, in the cycle after the second word, with both words on `rd_data0`/`rd_data1`.
- R7: Each read gets a tag equal to its issue count since reset, modulo 2^TAG_W. Pairs are delivered in issue order, carrying that tag on `rd_tag`.
- R8: A read never issues in the slot right after a write. The gap between the two commands is at least 8 cycles.
- R9: With `lat_long` high, a write never issues in the slot right after a read (gap at least 8 cycles). With `lat_long` low, a write may issue in the next slot, so a back-to-back read then write are exactly 4 cycles apart.
- R10: Once reset is released, `mem_rd_en`, `mem_wr_en`, `mem_d_oe` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the memory clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| lat_long | input | 1 | Static latency select: 1 = 2.5-cycle, 0 = 1-cycle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ADDR_W | Burst address |
| req_wdata0 | input | DATA_W | First write word |
| req_wdata1 | input | DATA_W | Second write word |
| req_be0 | input | DATA_W/9 | Byte enables for the first word |
| req_be1 | input | DATA_W/9 | Byte enables for the second word |
| rd_valid | output | 1 | Completed read pair on this cycle |
| rd_tag | output | TAG_W | Issue tag of the returned pair |
| rd_data0 | output | DATA_W | First read word |
| rd_data1 | output | DATA_W | Second read word |
| mem_k | output | 1 | Memory clock phase (high in command cycles) |
| mem_lat_long | output | 1 | Latency mode to the memory |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd_en | output | 1 | Read select, one cycle per burst |
| mem_wr_en | output | 1 | Write select, one cycle per burst |
| mem_bw | output | DATA_W/9 | Byte-write selects for the word on mem_d |
| mem_d | output | DATA_W | Write data |
| mem_d_oe | output | 1 | Write data drive enable |
| mem_q | input | DATA_W | Read data from the memory |
| mem_qvld | input | 1 | Read data valid strobe |

## Verification
The tag FIFO and strobe-pairing assertions rely on the memory raising `mem_qvld` only for reads the controller actually issued, exactly twice per read, in two consecutive cycles. They also rely on `lat_long` holding still between resets. The bench memory model keeps to this by producing each strobed pair from its own pipeline of issued read commands, at the delay chosen by the mode. The bench changes the mode only while reset is applied.

// File: rtl/ddrb_pkg.sv
// Shared definitions for the two-word burst SRAM controller.
// Assumes the internal clock runs at twice the memory clock, so one
// memory clock cycle spans two internal cycles.
package ddrb_pkg;
    // Internal cycles per command slot (two memory clock cycles).
    localparam int SLOT_LEN = 4;
    // Data bits covered by one byte-write select.
    localparam int BYTE_W = 9;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_READ  = 2'd1,
        SLOT_WRITE = 2'd2
    } slot_kind_e;
endpackage

// File: rtl/ddrb_slot_sched.sv
// Command slot scheduler. Counts memory half-cycles, opens one command
// slot every SLOT_LEN cycles and decides whether the request offered in
// that slot may go. Inserts an idle slot for read-after-write always and
// for write-after-read in the long latency mode.
// Assumes SLOT_LEN is 4, so phase bit 0 is the memory clock phase.
module ddrb_slot_sched
    import ddrb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lat_long,
    input  logic req_valid,
    input  logic req_write,
    input  logic rd_room,
    output logic req_ready,
    output logic accept,
    output logic mem_k
);
    localparam int PW = $clog2(SLOT_LEN);

    logic [PW-1:0] phase;
    slot_kind_e    last_kind;
    logic          slot_open;
    logic          turn_block;

    // Free-running half-cycle counter; wraps every slot.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + 1'b1;
    end

    assign slot_open = (phase == PW'(SLOT_LEN - 1));

    // Turnaround rule: block a direction change that could collide on the pins.
    always_comb begin
        if (req_write) turn_block = (last_kind == SLOT_READ) && lat_long;
        else           turn_block = (last_kind == SLOT_WRITE);
    end

    assign req_ready = slot_open && !turn_block && (req_write || rd_room);
    assign accept    = req_valid && req_ready;
    assign mem_k     = ~phase[0];

    // Remember what the most recent slot carried (idle if nothing went).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_kind <= SLOT_IDLE;
        end else if (slot_open) begin
            if (!accept)        last_kind <= SLOT_IDLE;
            else if (req_write) last_kind <= SLOT_WRITE;
            else                last_kind <= SLOT_READ;
        end
    end

    AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);  // R1
endmodule

// File: rtl/ddrb_wr_path.sv
// Write data path. Holds both words and masks of an accepted write and
// drives them on the data pins on the two half-cycles following the next
// memory clock rising edge after the command.
// Assumes writes are accepted no more often than once per slot.
module ddrb_wr_path
    import ddrb_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_take,
    input  logic [DATA_W-1:0]          wdata0,
    input  logic [DATA_W-1:0]          wdata1,
    input  logic [DATA_W/BYTE_W-1:0]   be0,
    input  logic [DATA_W/BYTE_W-1:0]   be1,
    output logic [DATA_W-1:0]          mem_d,
    output logic [DATA_W/BYTE_W-1:0]   mem_bw,
    output logic                       mem_d_oe
);
    localparam int BW_W = DATA_W / BYTE_W;

    logic [2:0]        stage;
    logic [DATA_W-1:0] hold_d0, hold_d1;
    logic [BW_W-1:0]   hold_b0, hold_b1;

    // Track the write through its command and data cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[1:0], wr_take};
    end

    // Capture the burst payload when the request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_d0 <= '0;
            hold_d1 <= '0;
            hold_b0 <= '0;
            hold_b1 <= '0;
        end else if (wr_take) begin
            hold_d0 <= wdata0;
            hold_d1 <= wdata1;
            hold_b0 <= be0;
            hold_b1 <= be1;
        end
    end

    // Drive word 0 then word 1 on consecutive half-cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_d    <= '0;
            mem_bw   <= '0;
            mem_d_oe <= 1'b0;
        end else if (stage[1]) begin
            mem_d    <= hold_d0;
            mem_bw   <= hold_b0;
            mem_d_oe <= 1'b1;
        end else if (stage[2]) begin
            mem_d    <= hold_d1;
            mem_bw   <= hold_b1;
            mem_d_oe <= 1'b1;
        end else begin
            mem_d    <= '0;
            mem_bw   <= '0;
            mem_d_oe <= 1'b0;
        end
    end

    AST_OE_TWO_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_d_oe) |=> mem_d_oe ##1 !mem_d_oe);  // R3
endmodule

// File: rtl/ddrb_tag_fifo.sv
// Small FIFO of read issue tags, popped as read pairs complete.
// Assumes DEPTH is a power of two and at least 2.
module ddrb_tag_fifo #(
    parameter int TAG_W = 4,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             pop,
    output logic [TAG_W-1:0] head_tag,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [TAG_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    // Store a new tag at the write pointer.
    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_tag;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_tag = slots[rd_ptr];
    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);  // R7
endmodule

// File: rtl/ddrb_rd_capture.sv
// Read return path. Tags reads at issue, pairs strobed words from the
// memory and delivers each pair with its tag in issue order.
// Assumes the strobe marks exactly two consecutive words per issued read.
module ddrb_rd_capture #(
    parameter int DATA_W    = 18,
    parameter int TAG_W     = 4,
    parameter int TAG_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_take,
    input  logic [DATA_W-1:0] mem_q,
    input  logic              mem_qvld,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data0,
    output logic [DATA_W-1:0] rd_data1,
    output logic              rd_room
);
    logic [TAG_W-1:0]  issue_tag, head_tag;
    logic [DATA_W-1:0] first_word;
    logic              second, pop, full, empty;

    // Number reads in the order they are accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)       issue_tag <= '0;
        else if (rd_take) issue_tag <= issue_tag + 1'b1;
    end

    ddrb_tag_fifo #(
        .TAG_W (TAG_W),
        .DEPTH (TAG_DEPTH)
    ) tags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rd_take),
        .push_tag (issue_tag),
        .pop      (pop),
        .head_tag (head_tag),
        .full     (full),
        .empty    (empty)
    );

    assign pop     = mem_qvld && second;
    assign rd_room = !full;

    // Pair strobed words: first goes to a holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second     <= 1'b0;
            first_word <= '0;
        end else if (mem_qvld) begin
            second <= !second;
            if (!second) first_word <= mem_q;
        end
    end

    // Present a completed pair for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_tag   <= '0;
            rd_data0 <= '0;
            rd_data1 <= '0;
        end else begin
            rd_valid <= pop;
            if (pop) begin
                rd_tag   <= head_tag;
                rd_data0 <= first_word;
                rd_data1 <= mem_q;
            end
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);  // R7
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);  // R6
endmodule

// File: rtl/ddrb_ctrl.sv
// Top of the two-word burst DDR SRAM controller. Takes user bursts on a
// valid/ready port, issues one command per slot to the memory, drives the
// write burst and returns strobed read pairs in issue order.
// Assumes lat_long is static between resets and the memory strobes
// exactly one word pair per issued read.
module ddrb_ctrl
    import ddrb_pkg::*;
#(
    parameter int DATA_W    = 18,
    parameter int ADDR_W    = 20,
    parameter int TAG_W     = 4,
    parameter int TAG_DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lat_long,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata0,
    input  logic [DATA_W-1:0]         req_wdata1,
    input  logic [DATA_W/BYTE_W-1:0]  req_be0,
    input  logic [DATA_W/BYTE_W-1:0]  req_be1,
    output logic                      rd_valid,
    output logic [TAG_W-1:0]          rd_tag,
    output logic [DATA_W-1:0]         rd_data0,
    output logic [DATA_W-1:0]         rd_data1,
    output logic                      mem_k,
    output logic                      mem_lat_long,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic                      mem_rd_en,
    output logic                      mem_wr_en,
    output logic [DATA_W/BYTE_W-1:0]  mem_bw,
    output logic [DATA_W-1:0]         mem_d,
    output logic                      mem_d_oe,
    input  logic [DATA_W-1:0]         mem_q,
    input  logic                      mem_qvld
);
    logic accept, rd_room, cmd_any;

    ddrb_slot_sched sched_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat_long  (lat_long),
        .req_valid (req_valid),
        .req_write (req_write),
        .rd_room   (rd_room),
        .req_ready (req_ready),
        .accept    (accept),
        .mem_k     (mem_k)
    );

    // Register the command and address for the memory's command edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_en <= 1'b0;
            mem_wr_en <= 1'b0;
            mem_addr  <= '0;
        end else begin
            mem_rd_en <= accept && !req_write;
            mem_wr_en <= accept && req_write;
            if (accept) mem_addr <= req_addr;
        end
    end

    ddrb_wr_path #(
        .DATA_W (DATA_W)
    ) wr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_take  (accept && req_write),
        .wdata0   (req_wdata0),
        .wdata1   (req_wdata1),
        .be0      (req_be0),
        .be1      (req_be1),
        .mem_d    (mem_d),
        .mem_bw   (mem_bw),
        .mem_d_oe (mem_d_oe)
    );

    ddrb_rd_capture #(
        .DATA_W    (DATA_W),
        .TAG_W     (TAG_W),
        .TAG_DEPTH (TAG_DEPTH)
    ) rd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_take  (accept && !req_write),
        .mem_q    (mem_q),
        .mem_qvld (mem_qvld),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_data0 (rd_data0),
        .rd_data1 (rd_data1),
        .rd_room  (rd_room)
    );

    assign mem_lat_long = lat_long;
    assign cmd_any      = mem_rd_en || mem_wr_en;

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));  // R2
    AST_CMD_ON_KHIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_any |-> mem_k);  // R1
    AST_CMD_SPACE1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_any |=> !cmd_any);  // R1
    AST_CMD_SPACE2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_any |-> ##2 !cmd_any);  // R1
    AST_CMD_SPACE3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_any |-> ##3 !cmd_any);  // R1
    AST_WR_DATA_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ##2 mem_d_oe ##1 mem_d_oe);  // R3
    AST_RAW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ##4 !mem_rd_en);  // R8
    AST_WAR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && lat_long) |-> ##4 !mem_wr_en);  // R9
endmodule

// File: tb/ddrb_ctrl_tb_top.sv
// Self-checking bench with a cycle-accurate burst memory model.
module ddrb_ctrl_tb_top;
    localparam int DW = 18;
    localparam int AW = 4;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lat_long = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata0 = '0, req_wdata1 = '0;
    logic [1:0]    req_be0 = '0, req_be1 = '0;
    logic          rd_valid;
    logic [TW-1:0] rd_tag;
    logic [DW-1:0] rd_data0, rd_data1;
    logic          mem_k, mem_lat_long, mem_rd_en, mem_wr_en, mem_d_oe;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_bw;
    logic [DW-1:0] mem_d;
    logic [DW-1:0] mem_q = '0;
    logic          mem_qvld = 1'b0;

    always #4 clk = ~clk;

    ddrb_ctrl #(.DATA_W(DW), .ADDR_W(AW), .TAG_W(TW), .TAG_DEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .lat_long(lat_long),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata0(req_wdata0), .req_wdata1(req_wdata1),
        .req_be0(req_be0), .req_be1(req_be1),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data0(rd_data0), .rd_data1(rd_data1),
        .mem_k(mem_k), .mem_lat_long(mem_lat_long), .mem_addr(mem_addr),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_bw(mem_bw),
        .mem_d(mem_d), .mem_d_oe(mem_d_oe), .mem_q(mem_q), .mem_qvld(mem_qvld)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [DW-1:0] nw,
                                            input logic [1:0] be);
        logic [DW-1:0] r;
        r = old;
        if (be[0]) r[8:0]  = nw[8:0];
        if (be[1]) r[17:9] = nw[17:9];
        return r;
    endfunction

    // Behavioural memory: short/long read latency, strobe, byte-masked writes.
    logic [DW-1:0] marr [16][2];
    logic [4:0]    rv = '0;
    logic [AW-1:0] ra [5];
    logic [2:0]    wv = '0;
    logic [AW-1:0] wa [3];
    always @(posedge clk) begin
        rv <= {rv[3:0], mem_rd_en};
        ra[0] <= mem_addr;
        for (int i = 1; i < 5; i++) ra[i] <= ra[i-1];
        wv <= {wv[1:0], mem_wr_en};
        wa[0] <= mem_addr;
        for (int i = 1; i < 3; i++) wa[i] <= wa[i-1];
        if (wv[1]) marr[wa[1]][0] <= merge(marr[wa[1]][0], mem_d, mem_bw);
        if (wv[2]) marr[wa[2]][1] <= merge(marr[wa[2]][1], mem_d, mem_bw);
        mem_qvld <= 1'b0;
        mem_q    <= '0;
        if (mem_lat_long) begin
            if (rv[3])      begin mem_qvld <= 1'b1; mem_q <= marr[ra[3]][0]; end
            else if (rv[4]) begin mem_qvld <= 1'b1; mem_q <= marr[ra[4]][1]; end
        end else begin
            if (rv[0])      begin mem_qvld <= 1'b1; mem_q <= marr[ra[0]][0]; end
            else if (rv[1]) begin mem_qvld <= 1'b1; mem_q <= marr[ra[1]][1]; end
        end
    end

    // Expected read returns, filled by the stimulus, drained by the monitor.
    logic [DW-1:0] exp_d0 [128];
    logic [DW-1:0] exp_d1 [128];
    logic [TW-1:0] exp_tg [128];
    int            q_head = 0;
    int            q_tail = 0;
    logic [DW-1:0] sh [16][2];
    logic [TW-1:0] tag_ctr = '0;

    // Port monitor, sampled at the falling edge.
    int   cyc = 0;
    int   prev_cyc = -1;
    bit   prev_wr = 1'b0;
    int   last_rd_cyc = 0;
    int   last_wr_cyc = 0;
    logic [2:0] wh = '0;
    int   qwords = 0;
    bit   pend_rv = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_en || mem_wr_en) begin
                chk(mem_k == 1'b1, "R1", "command off clock-high phase", 64'(mem_k), 64'd1);
                chk(!(mem_rd_en && mem_wr_en), "R2", "both selects", 64'({mem_rd_en, mem_wr_en}), 64'd0);
                if (prev_cyc >= 0) begin
                    chk(cyc - prev_cyc >= 4, "R1", "command spacing", 64'(cyc - prev_cyc), 64'd4);
                    if (mem_rd_en && prev_wr)
                        chk(cyc - prev_cyc >= 8, "R8", "read after write gap", 64'(cyc - prev_cyc), 64'd8);
                    if (mem_wr_en && !prev_wr && lat_long)
                        chk(cyc - prev_cyc >= 8, "R9", "write after read gap", 64'(cyc - prev_cyc), 64'd8);
                end
                prev_cyc = cyc;
                prev_wr  = mem_wr_en;
                if (mem_rd_en) last_rd_cyc = cyc;
                else           last_wr_cyc = cyc;
            end
            if (wh[1] || wh[2] || mem_d_oe)
                chk(mem_d_oe == (wh[1] || wh[2]), "R3", "data drive window", 64'(mem_d_oe), 64'(wh[1] || wh[2]));
            if (mem_d_oe && mem_qvld)
                chk(1'b0, "R8", "write data meets read data", 64'd1, 64'd0);
            wh = {wh[1:0], mem_wr_en};
            if (pend_rv || rd_valid)
                chk(rd_valid == pend_rv, "R6", "pair delivery cycle", 64'(rd_valid), 64'(pend_rv));
            pend_rv = 1'b0;
            if (mem_qvld) begin
                qwords++;
                pend_rv = (qwords % 2 == 0);
            end
            if (rd_valid) begin
                if (q_head == q_tail) begin
                    chk(1'b0, "R7", "unexpected read pair", 64'(rd_tag), 64'd0);
                end else begin
                    chk(rd_data0 == exp_d0[q_head], "R6", "read word 0", 64'(rd_data0), 64'(exp_d0[q_head]));
                    chk(rd_data1 == exp_d1[q_head], "R4", "read word 1", 64'(rd_data1), 64'(exp_d1[q_head]));
                    chk(rd_tag == exp_tg[q_head], "R7", "read tag order", 64'(rd_tag), 64'(exp_tg[q_head]));
                    q_head++;
                end
            end
        end else begin
            prev_cyc = -1;
            wh       = '0;
            qwords   = 0;
            pend_rv  = 1'b0;
        end
        cyc++;
    end

    // One burst request through the handshake, with command check (R5).
    task automatic send(input bit wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                        input logic [1:0] b0, input logic [1:0] b1);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_wdata0 = d0; req_wdata1 = d1; req_be0 = b0; req_be1 = b1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        if (wr) begin
            sh[a][0] = merge(sh[a][0], d0, b0);
            sh[a][1] = merge(sh[a][1], d1, b1);
        end else begin
            exp_d0[q_tail] = sh[a][0];
            exp_d1[q_tail] = sh[a][1];
            exp_tg[q_tail] = tag_ctr;
            tag_ctr = tag_ctr + 1'b1;
            q_tail++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_wr_en == wr && mem_rd_en == !wr, "R5", "command after accept",
            64'({mem_wr_en, mem_rd_en}), 64'({wr, !wr}));
        chk(mem_addr == a, "R5", "address after accept", 64'(mem_addr), 64'(a));
    endtask

    task automatic drain();
        int n;
        n = 0;
        while (q_head != q_tail && n < 100) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
        chk(q_head == q_tail, "R6", "all reads returned", 64'(q_tail - q_head), 64'd0);
    endtask

    bit done = 1'b0;

    initial begin
        for (int m = 1; m >= 0; m--) begin
            rst_n = 1'b0;
            lat_long = m[0];
            tag_ctr = '0;
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            chk(!mem_rd_en && !mem_wr_en && !mem_d_oe && !rd_valid, "R10", "reset state",
                64'({mem_rd_en, mem_wr_en, mem_d_oe, rd_valid}), 64'd0);
            chk(mem_lat_long == m[0], "R5", "latency mode pass-through", 64'(mem_lat_long), 64'(m));
            // full-width writes to every address
            for (int a = 0; a < 16; a++)
                send(1'b1, 4'(a), DW'(a * 4111 + m * 977 + 5), DW'(a * 7919 + m * 313 + 11), 2'b11, 2'b11);
            // every byte-enable combination once (R4)
            for (int a = 0; a < 16; a++)
                send(1'b1, 4'(a), DW'(a * 9973 + 123457), DW'(a * 271 + 200003), 2'(a), 2'(a >> 2));
            // back-to-back reads across the whole space (R6, R7)
            for (int a = 0; a < 16; a++)
                send(1'b0, 4'(15 - a), '0, '0, 2'b00, 2'b00);
            // write then read of the same address (R8)
            for (int k = 0; k < 6; k++) begin
                send(1'b1, 4'(k * 3), DW'(k * 55555 + m), DW'(k * 33333 + 7), 2'(k + 1), 2'(3 - k));
                send(1'b0, 4'(k * 3), '0, '0, 2'b00, 2'b00);
                #1;
                chk(last_rd_cyc - last_wr_cyc == 8, "R8", "idle slot before read",
                    64'(last_rd_cyc - last_wr_cyc), 64'd8);
            end
            // read then write, gap depends on mode (R9)
            for (int k = 0; k < 4; k++) begin
                send(1'b0, 4'(k + 8), '0, '0, 2'b00, 2'b00);
                send(1'b1, 4'(k + 12), DW'(k * 1234 + 99), DW'(k * 4321 + 77), 2'b11, 2'b01);
                #1;
                chk(last_wr_cyc - last_rd_cyc == (m ? 8 : 4), "R9", "write after read spacing",
                    64'(last_wr_cyc - last_rd_cyc), 64'(m ? 8 : 4));
            end
            for (int a = 8; a < 16; a++)
                send(1'b0, 4'(a), '0, '0, 2'b00, 2'b00);
            drain();
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule